// File: doc/BRIEF.md
# Line-Cycle Synchronized Energy Accumulator

This block integrates a stream of power samples over a window measured in half line cycles rather than in clock ticks. A zero-crossing detector upstream delivers one single-clock pulse per half cycle. The first pulse after reset opens the first window. Every later pulse advances a half-cycle count. When that count reaches the programmed length, the window closes and the next one opens on the same pulse. No sample is dropped or counted twice at the boundary.

At each window close, a wide internal sum is snapshotted and passed through a programmable integer divider. The 24-bit quotient is then written to the readable energy output. At the same moment a sticky end-of-window flag is set. If the host has the flag unmasked, an active-low interrupt is driven. Energy for a calibration interval can therefore be compared over exactly the same number of line half cycles each time. The block runs at all times and has no enable.

Top module: `linecyc_energy_acc`

## Requirements
- R1: A power sample is taken on every fourth rising clock edge after reset is released (edges 4, 8, 12, ...). The sample is the 24-bit power word, read as two's complement and sign-extended to 48 bits. It is added to the internal 48-bit sum only while a window is open.
- R2: Samples that arrive before the first zero-crossing pulse after reset contribute nothing. The first pulse opens the first window with the sum cleared.
- R3: Call the programmed half-cycle count N. The window closes on the N-th pulse counted after the pulse that opened it. The same pulse opens the next window. A sample taken on that closing edge belongs to the new window.
- R4: For each closed window, the energy output takes the low 24 bits of (window sum / divisor), truncated toward zero. The value appears 49 clock edges after the closing edge and holds until the next result.
- R5: The 8-bit divisor is captured on the closing edge. A value of 0 divides by 1, and a value d from 1 to 255 divides by d.
- R6: A programmed half-cycle count of 0 behaves as a count of 1.
- R7: The end-of-window flag is set on the same edge that writes the energy output. It stays set until a clear strobe is sampled high. If a set and a clear arrive on the same edge, the set wins.
- R8: The interrupt output is low exactly when the flag is set and the mask input is high. It returns high as soon as either condition is removed.
- R9: After reset the energy output is 0, the flag is 0 and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_word | input | 24 | Power sample, two's complement |
| zc_pulse | input | 1 | One-cycle pulse per half line cycle |
| half_cycles | input | 16 | Window length in half cycles (0 acts as 1) |
| energy_div | input | 8 | Output divisor (0 acts as 1) |
| cyc_mask | input | 1 | High lets the flag drive the interrupt |
| cyc_clr | input | 1 | Clear strobe for the flag |
| energy_out | output | 24 | Divided energy of the last closed window |
| cyc_flag | output | 1 | Sticky end-of-window flag |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions check several rules on every cycle. The flag and the energy output may change only after the divider reports completion. The flag holds until a clear arrives and drops after a clear that has no competing set. The interrupt can be low only while the flag is set and the mask is high. A window close always starts the divider. These rules cannot show whether the result is numerically right, whether the windows have the right length, or whether samples on the boundary land in the right window. The bench's scenarios show those properties through a cycle-accurate model: samples before the first crossing, lengths of one and zero, divisors of zero and odd values, negative sums, and a clear strobe that lands on the result edge.

// File: rtl/lce_pkg.sv
`timescale 1ns/1ps
// lce_pkg: shared definitions for the line-cycle energy accumulator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lce_pkg;
    // Window controller state: waiting for the first crossing, or counting.
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_e;
endpackage

// File: rtl/lce_sample_tick.sv
`timescale 1ns/1ps
// lce_sample_tick: emits a one-cycle tick every DIV clocks, counting from
// reset release. The first tick comes on the DIV-th edge after release.
// Assumes DIV >= 2.
module lce_sample_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    // Free-running modulo-DIV phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/lce_window_ctl.sv
`timescale 1ns/1ps
// lce_window_ctl: counts zero-crossing pulses into half-cycle windows.
// The first pulse after reset opens a window. The pulse that makes the count
// reach the target closes the window and opens the next one at once.
// Assumes zc is a single-clock pulse. A target of 0 acts as 1.
module lce_window_ctl
    import lce_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zc,
    input  logic [CNT_W-1:0] target,
    output logic             win_open,
    output logic             win_close,
    output logic             running
);
    win_state_e       st_q;
    logic [CNT_W-1:0] hc_q;
    logic [CNT_W-1:0] tgt_eff;
    logic             reached;

    // Guard against a zero-length window.
    always_comb tgt_eff = (target == '0) ? CNT_W'(1) : target;

    // Compare with one extra bit so the increment cannot wrap.
    always_comb reached = ({1'b0, hc_q} + 1'b1) >= {1'b0, tgt_eff};

    assign running   = (st_q == WIN_RUN);
    assign win_open  = zc && (st_q == WIN_IDLE);
    assign win_close = zc && running && reached;

    // State and half-cycle counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= WIN_IDLE;
            hc_q <= '0;
        end else if (win_open || win_close) begin
            st_q <= WIN_RUN;
            hc_q <= '0;
        end else if (zc && running) begin
            hc_q <= hc_q + 1'b1;
        end
    end
endmodule

// File: rtl/lce_seq_div.sv
`timescale 1ns/1ps
// lce_seq_div: signed-by-unsigned restoring divider, one quotient bit per
// clock. A start pulse captures the dividend (two's complement) and the
// divisor (0 acts as 1). NUM_W edges later, done pulses for one cycle, and
// quotient holds the low OUT_W bits of the quotient truncated toward zero.
// Assumes no new start arrives while busy, and OUT_W <= NUM_W.
module lce_seq_div #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 8,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] quotient
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic             neg_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [OUT_W-1:0] res_q;

    logic [DEN_W:0]   rem_sh;
    logic             ge;
    logic [DEN_W-1:0] rem_nx;
    logic [NUM_W-1:0] quo_nx;
    logic [OUT_W-1:0] res_nx;

    // One restoring step: shift in the next dividend bit, try to subtract.
    always_comb begin
        rem_sh = {rem_q, quo_q[NUM_W-1]};
        ge     = rem_sh >= {1'b0, den_q};
        rem_nx = ge ? (rem_sh[DEN_W-1:0] - den_q) : rem_sh[DEN_W-1:0];
        quo_nx = {quo_q[NUM_W-2:0], ge};
        res_nx = neg_q ? (~quo_nx[OUT_W-1:0] + 1'b1) : quo_nx[OUT_W-1:0];
    end

    // Operand capture, iteration and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= DEN_W'(1);
            neg_q  <= 1'b0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                neg_q  <= dividend[NUM_W-1];
                quo_q  <= dividend[NUM_W-1] ? (~dividend + 1'b1) : dividend;
                rem_q  <= '0;
                den_q  <= (divisor == '0) ? DEN_W'(1) : divisor;
                cnt_q  <= CW'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                quo_q <= quo_nx;
                rem_q <= rem_nx;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= res_nx;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = res_q;
endmodule

// File: rtl/linecyc_energy_acc.sv
`timescale 1ns/1ps
// linecyc_energy_acc: integrates power samples over a programmed number of
// half line cycles. At each window close it divides the sum and publishes it
// with a sticky flag and an active-low interrupt.
// Assumes closes are at least ACC_W+2 clocks apart (the divider is busy for
// ACC_W clocks), and that zc_pulse is one clock wide.
module linecyc_energy_acc #(
    parameter int PWR_W      = 24,
    parameter int ACC_W      = 48,
    parameter int OUT_W      = 24,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 8,
    parameter int SAMPLE_DIV = 4,
    parameter bit PWR_SIGNED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWR_W-1:0] pwr_word,
    input  logic             zc_pulse,
    input  logic [CNT_W-1:0] half_cycles,
    input  logic [DIV_W-1:0] energy_div,
    input  logic             cyc_mask,
    input  logic             cyc_clr,
    output logic [OUT_W-1:0] energy_out,
    output logic             cyc_flag,
    output logic             irq_n
);
    localparam int EXT_W = ACC_W - PWR_W;

    logic             tick;
    logic             win_open;
    logic             win_close;
    logic             running;
    logic             div_busy;
    logic             div_done;
    logic [OUT_W-1:0] div_q;
    logic [ACC_W-1:0] pwr_ext;
    logic [ACC_W-1:0] samp;
    logic [ACC_W-1:0] acc_q;
    logic [OUT_W-1:0] energy_q;
    logic             flag_q;

    lce_sample_tick #(.DIV(SAMPLE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    lce_window_ctl #(.CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc        (zc_pulse),
        .target    (half_cycles),
        .win_open  (win_open),
        .win_close (win_close),
        .running   (running)
    );

    lce_seq_div #(.NUM_W(ACC_W), .DEN_W(DIV_W), .OUT_W(OUT_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (win_close),
        .dividend (acc_q),
        .divisor  (energy_div),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q)
    );

    // Widen the sample according to the chosen number format.
    generate
        if (PWR_SIGNED) begin : g_sext
            assign pwr_ext = {{EXT_W{pwr_word[PWR_W-1]}}, pwr_word};
        end else begin : g_zext
            assign pwr_ext = {{EXT_W{1'b0}}, pwr_word};
        end
    endgenerate

    // Only sample ticks contribute to the sum.
    always_comb samp = tick ? pwr_ext : '0;

    // Window sum: restart on open or close, accumulate while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                     acc_q <= '0;
        else if (win_open || win_close) acc_q <= samp;
        else if (running)               acc_q <= acc_q + samp;
    end

    // Publish the divided result when the divider finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)        energy_q <= '0;
        else if (div_done) energy_q <= div_q;
    end

    // Sticky end-of-window flag; a set beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (div_done) flag_q <= 1'b1;
        else if (cyc_clr)  flag_q <= 1'b0;
    end

    assign energy_out = energy_q;
    assign cyc_flag   = flag_q;
    assign irq_n      = ~(flag_q & cyc_mask);
endmodule

// File: rtl/lce_chk.sv
`timescale 1ns/1ps
// lce_chk: cycle-level rules for linecyc_energy_acc, bound to every instance.
// Assumes the synchronous active-low reset of the top module.
module lce_chk #(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_clr,
    input logic             cyc_mask,
    input logic             cyc_flag,
    input logic             irq_n,
    input logic [OUT_W-1:0] energy_out,
    input logic             div_done,
    input logic             div_busy,
    input logic             win_close
);
    // R7
    flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_flag) |-> $past(div_done));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_flag && !cyc_clr) |=> cyc_flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_clr && !div_done) |=> !cyc_flag);

    // R4
    energy_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(energy_out) |-> $past(div_done));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_mask |-> irq_n);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> cyc_flag);

    // R3
    close_starts_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> div_busy);
endmodule

bind linecyc_energy_acc lce_chk #(.OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_clr    (cyc_clr),
    .cyc_mask   (cyc_mask),
    .cyc_flag   (cyc_flag),
    .irq_n      (irq_n),
    .energy_out (energy_out),
    .div_done   (div_done),
    .div_busy   (div_busy),
    .win_close  (win_close)
);

// File: tb/linecyc_energy_acc_bench.sv
`timescale 1ns/1ps
module linecyc_energy_acc_bench;
    localparam int LAT = 49;   // R4: result edge = closing edge + ACC_W + 1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pwr = '0;
    logic        zc = 1'b0;
    logic [15:0] hc = 16'd1;
    logic [7:0]  dv = 8'd0;
    logic        mask = 1'b0;
    logic        clr = 1'b0;
    logic [23:0] energy;
    logic        flag;
    logic        irq_n;

    always #10 clk = ~clk;

    linecyc_energy_acc u_linecyc_energy_acc (
        .clk(clk), .rst_n(rst_n), .pwr_word(pwr), .zc_pulse(zc),
        .half_cycles(hc), .energy_div(dv), .cyc_mask(mask), .cyc_clr(clr),
        .energy_out(energy), .cyc_flag(flag), .irq_n(irq_n)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    longint      edge_n = 0;
    int          ph = 0;
    bit          run = 0;
    int          hcnt = 0;
    longint      acc = 0;
    bit          m_flag = 0;
    logic [23:0] m_energy = '0;
    bit          pend = 0;
    longint      due = 0;
    logic [23:0] pend_val = '0;

    // Expected result for a window sum (R4, R5).
    function automatic logic [23:0] exp_div(longint a, int d);
        longint dd = (d == 0) ? 1 : d;
        longint mag = (a < 0) ? -a : a;
        longint q = mag / dd;
        if (a < 0) q = -q;
        return q[23:0];
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    // Reference behaviour for one rising edge with the present inputs.
    task automatic model_edge();
        bit     tk;
        longint s;
        int     tgt;
        edge_n++;
        tk = (ph == 3);                       // R1
        ph = (ph + 1) % 4;
        s = tk ? longint'($signed(pwr)) : 0;
        tgt = (hc == 0) ? 1 : int'(hc);       // R6
        if (pend && edge_n == due) begin      // R4, R7
            m_energy = pend_val;
            m_flag = 1;
            pend = 0;
        end else if (clr) begin
            m_flag = 0;
        end
        if (zc && !run) begin                 // R2
            run = 1; hcnt = 0; acc = s;
        end else if (zc && (hcnt + 1 >= tgt)) begin   // R3
            pend_val = exp_div(acc, int'(dv));
            due = edge_n + LAT; pend = 1;
            hcnt = 0; acc = s;
        end else if (zc) begin
            hcnt++; acc += s;
        end else if (run) begin
            acc += s;
        end
    endtask

    task automatic compare();
        chk(energy === m_energy, "R4 energy", energy, m_energy);
        chk(flag === m_flag, "R7 flag", flag, m_flag);
        chk(irq_n === !(m_flag && mask), "R8 irq_n", irq_n, !(m_flag && mask));
    endtask

    task automatic drive_cycle(bit z, bit c);
        zc = z; clr = c; pwr = 24'($urandom);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    // gap-1 quiet cycles, then one crossing pulse.
    task automatic gap(int n, bit clr_due);
        for (int i = 0; i < n; i++) begin
            bit c = clr_due ? (pend && (edge_n + 1 == due)) : ($urandom % 40 == 0);
            drive_cycle(i == n - 1, c);
        end
    endtask

    initial begin
        void'($urandom(32'h1e7c_0a5d));
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(energy === 24'h0, "R9 energy", energy, 0);
        chk(flag === 1'b0, "R9 flag", flag, 0);
        chk(irq_n === 1'b1, "R9 irq_n", irq_n, 1);
        rst_n = 1'b1;
        // R2: samples before the first crossing are ignored
        mask = 1'b1;
        gap(30, 0);
        // R3, R5: single half-cycle windows, divisor 0
        hc = 16'd1; dv = 8'd0;
        for (int k = 0; k < 3; k++) gap(60, 0);
        // R6: zero length acts as one
        hc = 16'd0;
        for (int k = 0; k < 3; k++) gap(57, 0);
        // R5: odd divisor, multi half-cycle window
        hc = 16'd3; dv = 8'd7;
        for (int k = 0; k < 6; k++) gap(25, 0);
        // R7: clear strobe on the very edge the result lands
        hc = 16'd1; dv = 8'd3;
        for (int k = 0; k < 3; k++) gap(64, 1);
        // R8: masked interrupt
        mask = 1'b0;
        for (int k = 0; k < 2; k++) gap(60, 0);
        // Random mix of lengths, divisors, masks and clears
        for (int k = 0; k < 20; k++) begin
            hc = 16'($urandom_range(0, 4));
            dv = 8'($urandom);
            mask = 1'($urandom);
            gap(int'($urandom_range(55, 110)), 0);
        end
        hc = 16'd1;
        for (int k = 0; k < 70; k++) drive_cycle(0, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule